// File: doc/BRIEF.md
# Iterative Shift-Add Square Root Unit

This sequential block returns the integer square root of an unsigned operand. It settles one result bit per clock cycle, starting with the most significant. Each step forms a trial square using only shifts, additions and one comparison. The operand is taken when a request strobe is high and the block is idle. A completion flag then rises after a fixed number of cycles. The result and the flag stay put until the next request is accepted.

A second parameter sets the result width. When it equals half the operand width, the block produces the plain integer root. When it is larger, the operand is first shifted left by an even number of bits, so the root gains extra fractional bits. The number of fractional bits is the result width minus half the operand width. A running-square register keeps the square of the partial root, so each trial square is a small incremental sum rather than a product.

Top module: `sqrt_unit`

## Requirements
- R1: While reset is applied, and after release until the first accepted request, `out_valid` is 0 and `result` is 0.
- R2: If a request is accepted at clock edge k, `out_valid` goes high at edge k+M, where M is the result width.
- R3: With M = N/2, the completed `result` equals floor(sqrt(operand)).
- R4: With M > N/2, the completed `result` equals floor(sqrt(operand·2^(2M-N))), read with M-N/2 fractional bits. For example, with N=8 and M=6, operand 42 gives 25, which reads as 6.25.
- R5: Once `out_valid` is high, both it and `result` hold their values until the edge that accepts the next request.
- R6: With RESTART_EN=0, an `in_valid` pulse that arrives during a computation has no effect. The operand is not captured, the running result is delivered unchanged, and no extra completion follows.
- R7: `out_valid` goes low at the edge that accepts a new request.
- R8: The extreme operands give the following results. Operand 0 gives 0. Operand 1 gives 2^(M-N/2). The all-ones operand gives floor(sqrt((2^N-1)·2^(2M-N))): 15 for N=8, M=4 and 63 for N=8, M=6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request strobe; accepted when idle (or always if RESTART_EN=1) |
| operand | input | N | Unsigned value whose root is taken |
| out_valid | output | 1 | High from completion until the next accepted request |
| result | output | M | Root, with M-N/2 fractional bits |

## Verification
The bench builds two instances that share one 8-bit stimulus stream. The first uses M=6, which pre-shifts the operand by four bits and returns two fractional bits. The second uses M=4, the plain integer root. The narrow operand makes an exhaustive sweep of all 256 values cheap in both modes, covering the extremes and both latencies (6 and 4 cycles). It also lets a mid-computation request be seen against two instances that are busy for different lengths of time.

// File: rtl/sqrt_unit_pkg.sv
package sqrt_unit_pkg;
  // Width of the bit-index counter for a result of m bits.
  function automatic int unsigned idx_width(int unsigned m);
    return (m <= 1) ? 1 : $clog2(2 * m);
  endfunction
endpackage

// File: rtl/sqrt_unit_rstsync.sv
module sqrt_unit_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/sqrt_unit_ctrl.sv
module sqrt_unit_ctrl #(
  parameter int unsigned M          = 6,
  parameter bit          RESTART_EN = 1'b0,
  parameter int unsigned CW         = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          accept,
  output logic          busy,
  output logic [CW-1:0] idx,
  output logic [M-1:0]  bit_oh,
  output logic          out_valid
);
  logic          busy_q, busy_d;
  logic [CW-1:0] idx_q, idx_d;
  logic [M-1:0]  oh_q, oh_d;
  logic          ov_q, ov_d;
  logic          en;

  assign accept = in_valid && (!busy_q || RESTART_EN);
  assign en     = accept || busy_q;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    oh_d   = oh_q;
    ov_d   = ov_q;
    if (accept) begin
      busy_d = 1'b1;
      idx_d  = CW'(M - 1);
      oh_d   = M'(1) << (M - 1);
      ov_d   = 1'b0;
    end else if (busy_q) begin
      oh_d = oh_q >> 1;
      if (idx_q == '0) begin
        busy_d = 1'b0;
        ov_d   = 1'b1;
      end else begin
        idx_d = idx_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      oh_q   <= '0;
      ov_q   <= 1'b0;
    end else if (en) begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      oh_q   <= oh_d;
      ov_q   <= ov_d;
    end
  end

  assign busy      = busy_q;
  assign idx       = idx_q;
  assign bit_oh    = oh_q;
  assign out_valid = ov_q;
endmodule

// File: rtl/sqrt_unit_dp.sv
module sqrt_unit_dp #(
  parameter int unsigned N  = 8,
  parameter int unsigned M  = 6,
  parameter int unsigned CW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accept,
  input  logic           busy,
  input  logic [N-1:0]   operand,
  input  logic [CW-1:0]  idx,
  input  logic [M-1:0]   bit_oh,
  output logic [2*M-1:0] op_scaled,
  output logic [2*M-1:0] run_sq,
  output logic [M-1:0]   root
);
  localparam int unsigned W2 = 2 * M;
  localparam int unsigned DW = W2 + 1;
  localparam int unsigned SH = W2 - N;

  logic [W2-1:0] op_q, op_d;
  logic [W2-1:0] sq_q, sq_d;
  logic [M-1:0]  y_q, y_d;
  logic [DW-1:0] trial;
  logic          fits;
  logic          en;

  // (y + 2^i)^2 = y_sq + y*2^(i+1) + 2^(2i)
  always_comb begin
    trial = {1'b0, sq_q}
          + (DW'(y_q) << (idx + CW'(1)))
          + (DW'(bit_oh) << idx);
    fits  = trial <= {1'b0, op_q};
  end

  assign en = accept || busy;

  always_comb begin
    op_d = op_q;
    sq_d = sq_q;
    y_d  = y_q;
    if (accept) begin
      op_d = W2'(operand) << SH;
      sq_d = '0;
      y_d  = '0;
    end else if (fits) begin
      sq_d = trial[W2-1:0];
      y_d  = y_q | bit_oh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= '0;
      sq_q <= '0;
      y_q  <= '0;
    end else if (en) begin
      op_q <= op_d;
      sq_q <= sq_d;
      y_q  <= y_d;
    end
  end

  assign op_scaled = op_q;
  assign run_sq    = sq_q;
  assign root      = y_q;
endmodule

// File: rtl/sqrt_unit.sv
module sqrt_unit
  import sqrt_unit_pkg::*;
#(
  parameter int unsigned N          = 8,
  parameter int unsigned M          = 6,
  parameter bit          RESTART_EN = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [N-1:0] operand,
  output logic         out_valid,
  output logic [M-1:0] result
);
  localparam int unsigned CW = idx_width(M);

  logic           rst_sync_n;
  logic           accept;
  logic           busy;
  logic [CW-1:0]  idx;
  logic [M-1:0]   bit_oh;
  logic [2*M-1:0] op_q;
  logic [2*M-1:0] ysq_q;

  sqrt_unit_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sqrt_unit_ctrl #(.M(M), .RESTART_EN(RESTART_EN), .CW(CW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_valid  (in_valid),
    .accept    (accept),
    .busy      (busy),
    .idx       (idx),
    .bit_oh    (bit_oh),
    .out_valid (out_valid)
  );

  sqrt_unit_dp #(.N(N), .M(M), .CW(CW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .accept    (accept),
    .busy      (busy),
    .operand   (operand),
    .idx       (idx),
    .bit_oh    (bit_oh),
    .op_scaled (op_q),
    .run_sq    (ysq_q),
    .root      (result)
  );
endmodule

// File: rtl/sqrt_unit_chk.sv
module sqrt_unit_chk #(
  parameter int unsigned N          = 8,
  parameter int unsigned M          = 6,
  parameter bit          RESTART_EN = 1'b0
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [N-1:0]   operand,
  input logic           busy,
  input logic [2*M-1:0] op_q,
  input logic [2*M-1:0] ysq,
  input logic           out_valid,
  input logic [M-1:0]   result
);
  localparam int unsigned PW = 2 * M + 2;
  localparam int unsigned LW = $clog2(M + 2) + 1;

  logic          acc;
  logic [LW-1:0] lat_q;
  logic [PW-1:0] cap_q;
  logic [PW-1:0] r_ext;
  logic [PW-1:0] r1_ext;

  assign acc    = in_valid && (!busy || RESTART_EN);
  assign r_ext  = PW'(result);
  assign r1_ext = PW'(result) + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      cap_q <= '0;
    end else begin
      if (acc) begin
        lat_q <= LW'(1);
        cap_q <= PW'(operand) << (2 * M - N);
      end else if (lat_q != '0 && !out_valid) begin
        lat_q <= lat_q + LW'(1);
      end
    end
  end

  // R2: completion M edges after acceptance
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> lat_q == LW'(M + 1));

  // R3: running square tracks the partial root
  a_r3_running_square: assert property (@(posedge clk) disable iff (!rst_n)
    PW'(ysq) == r_ext * r_ext);

  // R4: completed root brackets the scaled operand
  a_r4_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && lat_q != '0) |-> (r_ext * r_ext <= cap_q) && (r1_ext * r1_ext > cap_q));

  // R5: held result
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !acc) |=> out_valid && $stable(result));

  // R6: busy-time request leaves the captured operand alone
  a_r6_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !acc) |=> $stable(op_q));

  // R7: flag drops on acceptance
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !out_valid);
endmodule

bind sqrt_unit sqrt_unit_chk #(.N(N), .M(M), .RESTART_EN(RESTART_EN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .operand   (operand),
  .busy      (busy),
  .op_q      (op_q),
  .ysq       (ysq_q),
  .out_valid (out_valid),
  .result    (result)
);

// File: tb/sqrt_unit_tb.sv
`timescale 1ns/1ps
module sqrt_unit_tb;
  localparam int N  = 8;
  localparam int MF = 6;
  localparam int MB = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [N-1:0] operand = '0;
  logic          ov_f, ov_b;
  logic [MF-1:0] res_f;
  logic [MB-1:0] res_b;

  sqrt_unit #(.N(N), .M(MF)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
    .out_valid(ov_f), .result(res_f));

  sqrt_unit #(.N(N), .M(MB)) u_dut_basic (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
    .out_valid(ov_b), .result(res_b));

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;
  int exp_f[$], st_f[$], exp_b[$], st_b[$];
  int last_f = 0, last_b = 0;
  bit prev_f = 1'b0, prev_b = 1'b0;
  int e_tmp, s_tmp;

  always @(posedge clk) cyc++;

  function automatic int isqrt(int v);
    int r = 0;
    while ((r + 1) * (r + 1) <= v) r++;
    return r;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: pop the scoreboard on each completion
  always @(negedge clk) begin
    if (rst_n) begin
      if (ov_f && !prev_f) begin
        if (exp_f.size() == 0) check("R6 extra completion (frac)", 1, 0);
        else begin
          e_tmp = exp_f.pop_front(); s_tmp = st_f.pop_front();
          check("R4 frac root", int'(res_f), e_tmp);
          check("R2 frac latency", cyc - s_tmp, MF);
          last_f = int'(res_f);
        end
      end
      if (ov_b && !prev_b) begin
        if (exp_b.size() == 0) check("R6 extra completion (basic)", 1, 0);
        else begin
          e_tmp = exp_b.pop_front(); s_tmp = st_b.pop_front();
          check("R3 basic root", int'(res_b), e_tmp);
          check("R2 basic latency", cyc - s_tmp, MB);
          last_b = int'(res_b);
        end
      end
      prev_f = ov_f;
      prev_b = ov_b;
    end
  end

  // Driver: one request, scoreboard entries, wait for both to finish
  task automatic send(int x);
    @(negedge clk);
    if (ov_f) check("R5 frac hold", int'(res_f), last_f);
    if (ov_b) check("R5 basic hold", int'(res_b), last_b);
    operand  = N'(x);
    in_valid = 1'b1;
    exp_f.push_back(isqrt(x << (2 * MF - N)));
    exp_b.push_back(isqrt(x));
    @(negedge clk);
    in_valid = 1'b0;
    st_f.push_back(cyc);
    st_b.push_back(cyc);
    check("R7 frac clear", int'(ov_f), 0);
    check("R7 basic clear", int'(ov_b), 0);
    repeat (MF + 1) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset flag frac", int'(ov_f), 0);
    check("R1 reset result frac", int'(res_f), 0);
    check("R1 reset flag basic", int'(ov_b), 0);
    check("R1 reset result basic", int'(res_b), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle flag frac", int'(ov_f), 0);
    check("R1 idle result basic", int'(res_b), 0);

    send(26);
    check("R3 example 26", int'(res_b), 5);
    send(42);
    check("R4 example 42", int'(res_f), 25);

    send(0);
    check("R8 zero frac", int'(res_f), 0);
    check("R8 zero basic", int'(res_b), 0);
    send(1);
    check("R8 one frac", int'(res_f), 4);
    check("R8 one basic", int'(res_b), 1);
    send(255);
    check("R8 all-ones frac", int'(res_f), 63);
    check("R8 all-ones basic", int'(res_b), 15);

    // R6: request while both instances are busy
    @(negedge clk);
    operand = 8'd200; in_valid = 1'b1;
    exp_f.push_back(isqrt(200 << (2 * MF - N)));
    exp_b.push_back(isqrt(200));
    @(negedge clk);
    in_valid = 1'b0;
    st_f.push_back(cyc); st_b.push_back(cyc);
    @(negedge clk);
    @(negedge clk);
    operand = 8'd3; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; operand = 8'd99;
    repeat (MF + 4) @(negedge clk);
    check("R6 frac kept first", int'(res_f), 56);
    check("R6 basic kept first", int'(res_b), 14);
    check("R6 no pending frac", exp_f.size(), 0);
    check("R6 no pending basic", exp_b.size(), 0);

    // R5: long idle hold
    repeat (20) @(negedge clk);
    check("R5 idle flag frac", int'(ov_f), 1);
    check("R5 idle result frac", int'(res_f), 56);
    check("R5 idle flag basic", int'(ov_b), 1);
    check("R5 idle result basic", int'(res_b), 14);

    // R3, R4: exhaustive sweep
    for (int x = 0; x < 256; x++) send(x);
    check("R3 sweep drained", exp_b.size(), 0);
    check("R4 sweep drained", exp_f.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule